// File: doc/BRIEF.md
# Fractional PLL Reprogramming Sequencer

This block retunes a fractional-multiplier PLL to a new output frequency. A client offers the wanted frequency in Hz on a valid/ready request port. The block splits that number into an integer multiplier word and a 24-bit fractional word. It then drives the PLL's configuration registers through a one-deep write port. It parks the PLL in standby and polls the lock input until lock is lost. Next it loads the divider, fraction, integer and spread settings, and puts the PLL back into normal mode. Finally it polls until lock is regained.

Both lock waits sample the lock input at a fixed interval, and the number of samples is bounded. If a wait runs out of samples, the sequence stops at once and raises an error status. Back-pressure rules:
- On the request side, a request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle.
- On the write side, a write is presented with `wr_valid`. Its address and data hold still until the cycle in which `wr_ready` is high.
- A new write may be presented in the very next cycle, which gives one write per cycle when the target never stalls.

Top module: `pll_reseq`

## Requirements
- R1: `req_ready` is high exactly while the sequencer is idle. A request taken with `req_valid && req_ready` makes `seq_busy` high and presents the first write in the next cycle. While the sequencer is busy, no further request is accepted.
- R2: The integer word is the frequency divided by 1,000,000. The fractional word is ((frequency mod 1,000,000) × 2^24) / 1,000,000, using integer division.
- R3: A successful request produces exactly six writes, in this order:
  - address 0, data 0x0001_0000: standby. Bit 16 is the run-control write enable.
  - address 1, data 0x0000_0211: reference divider 2 at bits 11:8, second post-divider 1 at bits 7:4, first post-divider 1 at bits 3:0.
  - address 3, data = fractional word << 8.
  - address 4, data = (integer word << 16) | 1.
  - address 5, data 0x0000_0016: spread setting.
  - address 0, data 0x0015_0001: normal mode. The write enables sit at bits 20, 18 and 16, and run control at bit 0.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. Each write completes in the cycle where both are high.
- R5: After the standby write, no further write is presented until the lock input has been sampled at 0.
- R6: After the standby or normal-mode write completes in cycle E, the lock input is sampled in cycle E+1 and then every POLL_CYC cycles. When the match is found at sample k, the next write completes no earlier than cycle E+2+(k-1)·POLL_CYC.
- R7: If lock is still 1 after ceil(TIMEOUT_CYC/POLL_CYC) samples in the unlock wait, the sequence ends with `seq_done` and `seq_err` high. No configuration write follows.
- R8: If lock is still 0 after the sample limit in the lock wait, the sequence ends with `seq_done` and `seq_err` high, after all six writes.
- R9: A lock value that matches on the last permitted sample counts as success, not as a timeout.
- R10: `seq_done` is a single-cycle pulse, and `seq_busy` is low in that cycle. `seq_err` holds its value until the next request is accepted, and a successful sequence leaves it at 0.
- R11: After reset the outputs are: `req_ready` 1, `seq_busy` 0, `wr_valid` 0, `seq_done` 0, `seq_err` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frequency request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_rate_hz | input | 32 | Requested output frequency in Hz |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 3 | Register index |
| wr_data | output | 32 | Register write data |
| pll_locked | input | 1 | Lock monitor from the PLL |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |
| seq_err | output | 1 | Last sequence ended on a lock timeout |

## Verification
Two events can land on the same lock sample: the lock input reaching its target value, and the sample budget running out. The bench sets the lock delay after the normal-mode write so that lock rises exactly at the last permitted sample, and expects success with `seq_err` low. One cycle later, the same delay must give a timeout. The sample cadence is judged from the spacing between the standby write and the first configuration write. A write-ready stall pattern shows that the order and the values hold under back-pressure.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STBY, ST_UNLK, ST_DIV, ST_FRAC, ST_INT, ST_SPRD, ST_NORM, ST_LOCK
  } seq_state_t;

  // register indices (decoded by the PLL register file)
  localparam int REG_CTRL = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_FRAC = 3;
  localparam int REG_INT  = 4;
  localparam int REG_SPRD = 5;

  // multiplier word widths
  localparam int INT_W  = 16;
  localparam int FRAC_W = 24;

  // control register fields
  localparam int RUN_BIT     = 0;
  localparam int RUN_WE_BIT  = 16;
  localparam int SSC_WE_BIT  = 18;
  localparam int DSPR_WE_BIT = 20;

  localparam logic [31:0] CTRL_STANDBY = 32'(1) << RUN_WE_BIT;
  localparam logic [31:0] CTRL_NORMAL  = (32'(1) << DSPR_WE_BIT) | (32'(1) << SSC_WE_BIT)
                                       | (32'(1) << RUN_WE_BIT)  | (32'(1) << RUN_BIT);

  // fixed divider and spread settings
  localparam int REF_DIV   = 2;
  localparam int POST_DIV1 = 1;
  localparam int POST_DIV2 = 1;
  localparam int SPREAD    = 'h16;

  localparam logic [31:0] DIV_WORD  = (32'(REF_DIV) << 8) | (32'(POST_DIV2) << 4) | 32'(POST_DIV1);
  localparam logic [31:0] SPRD_WORD = 32'(SPREAD);
  localparam logic [31:0] INT_RSV   = 32'd1;

endpackage

// File: rtl/pll_rate_split.sv
module pll_rate_split #(
  parameter int RATE_W = 32,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] rate_in,
  output logic [INT_W-1:0]  int_word,
  output logic [FRAC_W-1:0] frac_word
);
  localparam logic [63:0] HZ_PER_MHZ = 64'd1000000;

  logic [RATE_W-1:0] rate_q;
  logic [63:0]       rate_w, quot_w, rem_w, frac_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rate_q <= '0;
    else if (load) rate_q <= rate_in;
  end

  always_comb begin
    rate_w    = 64'(rate_q);
    quot_w    = rate_w / HZ_PER_MHZ;
    rem_w     = rate_w % HZ_PER_MHZ;
    frac_w    = (rem_w << FRAC_W) / HZ_PER_MHZ;
    int_word  = quot_w[INT_W-1:0];
    frac_word = frac_w[FRAC_W-1:0];
  end

endmodule

// File: rtl/pll_lock_poller.sv
module pll_lock_poller #(
  parameter int POLL_CYC    = 25000,
  parameter int TIMEOUT_CYC = 62500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic target,
  input  logic lock_in,
  output logic hit,
  output logic expire
);
  localparam int MAX_POLLS = (TIMEOUT_CYC + POLL_CYC - 1) / POLL_CYC;
  localparam int IW        = $clog2(POLL_CYC + 1);
  localparam int PW        = $clog2(MAX_POLLS + 1);

  logic          active, target_q, sample, match, last;
  logic [IW-1:0] tick;
  logic [PW-1:0] polls;

  always_comb begin
    sample = active && (tick == '0);
    match  = (lock_in == target_q);
    last   = (polls == PW'(MAX_POLLS - 1));
    hit    = sample && match;
    expire = sample && !match && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      target_q <= 1'b0;
      tick     <= '0;
      polls    <= '0;
    end else if (start) begin
      active   <= 1'b1;
      target_q <= target;
      tick     <= '0;
      polls    <= '0;
    end else if (hit || expire) begin
      active   <= 1'b0;
    end else if (active) begin
      tick <= (tick == IW'(POLL_CYC - 1)) ? '0 : tick + 1'b1;
      if (sample) polls <= polls + 1'b1;
    end
  end

  // R6
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sample && !start) |=> $stable(polls));

endmodule

// File: rtl/pll_wr_port.sv
module pll_wr_port #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              accepted
);
  assign accepted = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= load_addr;
      wr_data  <= load_data;
    end else if (accepted) begin
      wr_valid <= 1'b0;
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
  import pll_reseq_pkg::*;
#(
  parameter int RATE_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int POLL_CYC    = 25000,
  parameter int TIMEOUT_CYC = 62500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] req_rate_hz,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              pll_locked,
  output logic              seq_busy,
  output logic              seq_done,
  output logic              seq_err
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(REG_DIV);
  localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(REG_FRAC);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(REG_INT);
  localparam logic [ADDR_W-1:0] A_SPRD = ADDR_W'(REG_SPRD);

  seq_state_t        state, nxt;
  logic              take, accepted, hit, expire, poll_start, load, finish, fail;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic [INT_W-1:0]  int_word;
  logic [FRAC_W-1:0] frac_word;

  assign req_ready = (state == ST_IDLE);
  assign seq_busy  = (state != ST_IDLE);
  assign take      = req_valid && req_ready;

  pll_rate_split #(.RATE_W(RATE_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_split (
    .clk(clk), .rst_n(rst_n), .load(take), .rate_in(req_rate_hz),
    .int_word(int_word), .frac_word(frac_word));

  pll_lock_poller #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_poll (
    .clk(clk), .rst_n(rst_n), .start(poll_start), .target(state == ST_NORM),
    .lock_in(pll_locked), .hit(hit), .expire(expire));

  pll_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(ld_addr), .load_data(ld_data),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .accepted(accepted));

  always_comb begin
    nxt        = state;
    poll_start = 1'b0;
    finish     = 1'b0;
    fail       = 1'b0;
    unique case (state)
      ST_IDLE: if (take) nxt = ST_STBY;
      ST_STBY: if (accepted) begin nxt = ST_UNLK; poll_start = 1'b1; end
      ST_UNLK: begin
        if (hit) nxt = ST_DIV;
        else if (expire) begin nxt = ST_IDLE; finish = 1'b1; fail = 1'b1; end
      end
      ST_DIV:  if (accepted) nxt = ST_FRAC;
      ST_FRAC: if (accepted) nxt = ST_INT;
      ST_INT:  if (accepted) nxt = ST_SPRD;
      ST_SPRD: if (accepted) nxt = ST_NORM;
      ST_NORM: if (accepted) begin nxt = ST_LOCK; poll_start = 1'b1; end
      ST_LOCK: begin
        if (hit) begin nxt = ST_IDLE; finish = 1'b1; end
        else if (expire) begin nxt = ST_IDLE; finish = 1'b1; fail = 1'b1; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // a write is loaded on entry to a writing state
  always_comb begin
    load    = (nxt != state) && (nxt inside {ST_STBY, ST_DIV, ST_FRAC, ST_INT, ST_SPRD, ST_NORM});
    ld_addr = A_CTRL;
    ld_data = CTRL_STANDBY;
    unique case (nxt)
      ST_DIV:  begin ld_addr = A_DIV;  ld_data = DIV_WORD; end
      ST_FRAC: begin ld_addr = A_FRAC; ld_data = DATA_W'(frac_word) << 8; end
      ST_INT:  begin ld_addr = A_INT;  ld_data = (DATA_W'(int_word) << 16) | INT_RSV; end
      ST_SPRD: begin ld_addr = A_SPRD; ld_data = SPRD_WORD; end
      ST_NORM: begin ld_addr = A_CTRL; ld_data = CTRL_NORMAL; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      seq_done <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      state    <= nxt;
      seq_done <= finish;
      if (take)        seq_err <= 1'b0;
      else if (finish) seq_err <= fail;
    end
  end

  // R1
  take_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (seq_busy && wr_valid));

  // R5
  unlock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNLK) |-> !wr_valid);

  // R3
  spread_then_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_addr == A_SPRD) |=> (wr_valid && wr_addr == A_CTRL));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy);

endmodule

// File: tb/test_pll_reseq.sv
`timescale 1ns/1ps
module test_pll_reseq;
  localparam int P   = 4;
  localparam int TMO = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_rate_hz = '0;
  logic        wr_ready = 1'b1;
  logic        pll_locked = 1'b1;
  logic        req_ready, wr_valid, seq_busy, seq_done, seq_err;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;

  int n_chk = 0, n_fail = 0;
  int unlock_dly = 1, lock_dly = 1, stall = 0;
  int cnt_dn = 0, pend = 1, ncyc = 0, nlog = 0;
  logic [2:0]  log_a [16];
  logic [31:0] log_d [16];
  int          log_c [16];

  always #2 clk = ~clk;

  pll_reseq #(.POLL_CYC(P), .TIMEOUT_CYC(TMO)) i_pll_reseq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate_hz(req_rate_hz), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .pll_locked(pll_locked),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_err(seq_err));

  // PLL lock model, write-ready pattern and write logger
  initial forever begin
    @(negedge clk);
    ncyc++;
    if (cnt_dn > 0) begin
      cnt_dn--;
      if (cnt_dn == 0) pll_locked = pend[0];
    end
    wr_ready = (stall != 0) ? ((ncyc % 3) == 2) : 1'b1;
    if (wr_valid && wr_ready) begin
      if (nlog < 16) begin
        log_a[nlog] = wr_addr; log_d[nlog] = wr_data; log_c[nlog] = ncyc;
      end
      nlog++;
      if (wr_addr == 3'd0 && wr_data == 32'h0001_0000 && unlock_dly > 0) begin
        cnt_dn = unlock_dly; pend = 0;
      end
      if (wr_addr == 3'd0 && wr_data == 32'h0015_0001 && lock_dly > 0) begin
        cnt_dn = lock_dly; pend = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] rate, input int ud, input int ld, input int st);
    int n;
    unlock_dly = ud; lock_dly = ld; stall = st;
    @(negedge clk);
    nlog = 0;
    req_valid = 1'b1; req_rate_hz = rate;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0 && seq_busy == 1'b1, "R1 busy after take", {req_ready, seq_busy}, 2'b01);
    n = 0;
    while (!seq_done && n < 3000) begin @(negedge clk); n++; end
    chk(seq_done == 1'b1, "R10 done seen", seq_done, 1);
    chk(seq_busy == 1'b0, "R10 idle at done", seq_busy, 0);
    @(negedge clk);
    chk(seq_done == 1'b0, "R10 done one cycle", seq_done, 0);
  endtask

  task automatic check_writes(input logic [31:0] rate, input string tag);
    logic [63:0] iw, fw;
    iw = 64'(rate) / 64'd1000000;                          // R2
    fw = ((64'(rate) % 64'd1000000) << 24) / 64'd1000000;  // R2
    chk(nlog == 6, {tag, " R3 write count"}, nlog, 6);
    chk(log_a[0] == 3'd0 && log_d[0] == 32'h0001_0000, {tag, " R3 standby"}, {log_a[0], log_d[0]}, {3'd0, 32'h0001_0000});
    chk(log_a[1] == 3'd1 && log_d[1] == 32'h0000_0211, {tag, " R3 dividers"}, {log_a[1], log_d[1]}, {3'd1, 32'h211});
    chk(log_a[2] == 3'd3 && log_d[2] == 32'(fw << 8), {tag, " R2 fraction"}, {log_a[2], log_d[2]}, {3'd3, 32'(fw << 8)});
    chk(log_a[3] == 3'd4 && log_d[3] == (32'(iw << 16) | 32'd1), {tag, " R2 integer"}, {log_a[3], log_d[3]}, {3'd4, 32'(iw << 16) | 32'd1});
    chk(log_a[4] == 3'd5 && log_d[4] == 32'h16, {tag, " R3 spread"}, {log_a[4], log_d[4]}, {3'd5, 32'h16});
    chk(log_a[5] == 3'd0 && log_d[5] == 32'h0015_0001, {tag, " R3 normal"}, {log_a[5], log_d[5]}, {3'd0, 32'h0015_0001});
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1 && seq_busy == 1'b0 && wr_valid == 1'b0 && seq_done == 1'b0 && seq_err == 1'b0,
        "R11 reset state", {req_ready, seq_busy, wr_valid, seq_done, seq_err}, 5'b10000);
  endtask

  task automatic t_basic();
    run(32'd148_500_000, 1, 3, 0);
    check_writes(32'd148_500_000, "basic");
    chk(log_c[1] - log_c[0] == 2, "R6 first-sample gap", log_c[1] - log_c[0], 2);
    chk(seq_err == 1'b0, "R10 success err low", seq_err, 0);
  endtask

  task automatic t_poll_gap();
    run(32'd74_250_000, 6, 5, 0);
    check_writes(32'd74_250_000, "gap");
    chk(log_c[1] - log_c[0] == 2 + 2 * P, "R6 third-sample gap R5", log_c[1] - log_c[0], 2 + 2 * P);
  endtask

  task automatic t_stall();
    run(32'd33_333_333, 1, 2, 1);
    check_writes(32'd33_333_333, "stall R4");
    chk(seq_err == 1'b0, "R4 stall success", seq_err, 0);
  endtask

  task automatic t_unlock_timeout();
    run(32'd100_000_000, 0, 0, 0);
    chk(seq_err == 1'b1, "R7 unlock timeout err", seq_err, 1);
    chk(nlog == 1, "R7 only standby written", nlog, 1);
    repeat (5) @(negedge clk);
    chk(seq_err == 1'b1 && wr_valid == 1'b0, "R10 err held", {seq_err, wr_valid}, 2'b10);
  endtask

  task automatic t_last_sample();
    run(32'd50_000_000, 1, 1 + (TMO / P - 1) * P, 0);
    chk(seq_err == 1'b0, "R9 match on last sample", seq_err, 0);
    check_writes(32'd50_000_000, "last R9");
  endtask

  task automatic t_lock_timeout();
    run(32'd60_500_000, 1, 2 + (TMO / P - 1) * P, 0);
    chk(seq_err == 1'b1, "R8 lock timeout err", seq_err, 1);
    chk(nlog == 6, "R8 all writes done", nlog, 6);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_poll_gap();
    t_stall();
    t_unlock_timeout();
    t_last_sample();
    t_lock_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule